// File: doc/BRIEF.md
# Gate Passage Direction Detector

This block watches two beam-break sensors mounted one behind the other across a single vehicle gate. The outer beam sits on the street side and the inner beam on the lot side. A sensor reads 1 while its beam is blocked. From the order in which the beams are broken and cleared, the block decides whether a vehicle has gone all the way in or all the way out. It then raises a one-clock pulse on the matching output. An occupancy counter downstream consumes these pulses.

A vehicle long enough to cover both beams at once produces a four-phase Gray-code pattern. The detector follows that pattern state by state. It lets the vehicle stall or back up at any point, and it reports a passage only when the whole pattern has been walked in one direction. Objects too short to cover both beams, such as a person on foot, are rejected. Any pattern that breaks the expected order is also rejected, and the machine parks until both beams are clear again. Both sensor inputs must already be synchronous to the clock.

Top module: `gate_pass_detector`

## Requirements
- R1: A synchronous active-high reset drives both outputs low and returns the machine to idle. Any passage in progress at reset is abandoned and produces no pulse.
- R2: The sensor pair {outer, inner} stepping 00, 10, 11, 01, 00 raises car_in high for the cycle that follows the clock edge sampling the final 00.
- R3: The sequence 00, 01, 11, 10, 00 raises car_out high for the cycle that follows the clock edge sampling the final 00.
- R4: Each completed passage gives exactly one pulse one cycle wide, however long any phase or the closing 00 is held.
- R5: During an entry, stepping back one phase returns the machine to the earlier entry phase. A vehicle that fully backs out (ending in 00 after 10) gives no pulse. A vehicle that backs up and then resumes forward still gives car_in.
- R6: The same backing-up rules as R5 hold for an exit, with the roles of the sensors swapped.
- R7: An object that never covers both beams gives no pulse. This covers 10 then 00, 10 then 01, 01 then 00, and 01 then 10.
- R8: Any other out-of-order step, including 11 straight from idle, parks the machine with no pulse until the pair reads 00. A later normal passage is then recognised.
- R9: car_in and car_out are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sens_outer | input | 1 | Street-side beam, 1 = blocked |
| sens_inner | input | 1 | Lot-side beam, 1 = blocked |
| car_in | output | 1 | One-cycle pulse per completed entry |
| car_out | output | 1 | One-cycle pulse per completed exit |

## Verification
Every cycle, the assertions check the following. The two pulses never overlap. Each pulse lasts one cycle and follows the final phase of its own direction with both beams clear. The state moves correctly for a one-phase reversal, for a short object, and for a parked wait. Whether a whole multi-phase history yields exactly the right number of pulses can only be shown by the bench's scenarios. Those scenarios include long dwells, back-outs followed by a resumed passage, mid-passage reset and recovery after an illegal pattern.

// File: rtl/gate_pass_pkg.sv
package gate_pass_pkg;

  // passage phases; IN_* follow an entry, OUT_* an exit, WAIT parks until clear
  typedef enum logic [2:0] {
    GP_IDLE   = 3'd0,
    GP_IN_A   = 3'd1,
    GP_IN_AB  = 3'd2,
    GP_IN_B   = 3'd3,
    GP_OUT_B  = 3'd4,
    GP_OUT_AB = 3'd5,
    GP_OUT_A  = 3'd6,
    GP_WAIT   = 3'd7
  } gp_state_t;

  localparam int GP_LANES    = 2;
  localparam int GP_LANE_IN  = 0;
  localparam int GP_LANE_OUT = 1;

  // sensor pair codes, outer beam in bit 1
  localparam logic [1:0] AB_CLR   = 2'b00;
  localparam logic [1:0] AB_OUTER = 2'b10;
  localparam logic [1:0] AB_BOTH  = 2'b11;
  localparam logic [1:0] AB_INNER = 2'b01;

endpackage

// File: rtl/gate_pass_next.sv
module gate_pass_next
  import gate_pass_pkg::*;
#(
  parameter int LANES = GP_LANES
) (
  input  gp_state_t         st,
  input  logic [1:0]        ab,
  output gp_state_t         nxt,
  output logic [LANES-1:0]  done
);

  always_comb begin
    nxt  = st;
    done = '0;
    unique case (st)
      GP_IDLE: begin
        case (ab)
          AB_OUTER: nxt = GP_IN_A;
          AB_INNER: nxt = GP_OUT_B;
          AB_BOTH:  nxt = GP_WAIT;
          default:  nxt = GP_IDLE;
        endcase
      end
      GP_IN_A: begin
        case (ab)
          AB_BOTH:  nxt = GP_IN_AB;
          AB_CLR:   nxt = GP_IDLE;
          AB_INNER: nxt = GP_WAIT;
          default:  nxt = GP_IN_A;
        endcase
      end
      GP_IN_AB: begin
        case (ab)
          AB_INNER: nxt = GP_IN_B;
          AB_OUTER: nxt = GP_IN_A;
          AB_CLR:   nxt = GP_IDLE;
          default:  nxt = GP_IN_AB;
        endcase
      end
      GP_IN_B: begin
        case (ab)
          AB_CLR: begin
            nxt              = GP_IDLE;
            done[GP_LANE_IN] = 1'b1;
          end
          AB_BOTH:  nxt = GP_IN_AB;
          AB_OUTER: nxt = GP_WAIT;
          default:  nxt = GP_IN_B;
        endcase
      end
      GP_OUT_B: begin
        case (ab)
          AB_BOTH:  nxt = GP_OUT_AB;
          AB_CLR:   nxt = GP_IDLE;
          AB_OUTER: nxt = GP_WAIT;
          default:  nxt = GP_OUT_B;
        endcase
      end
      GP_OUT_AB: begin
        case (ab)
          AB_OUTER: nxt = GP_OUT_A;
          AB_INNER: nxt = GP_OUT_B;
          AB_CLR:   nxt = GP_IDLE;
          default:  nxt = GP_OUT_AB;
        endcase
      end
      GP_OUT_A: begin
        case (ab)
          AB_CLR: begin
            nxt               = GP_IDLE;
            done[GP_LANE_OUT] = 1'b1;
          end
          AB_BOTH:  nxt = GP_OUT_AB;
          AB_INNER: nxt = GP_WAIT;
          default:  nxt = GP_OUT_A;
        endcase
      end
      default: begin
        nxt = (ab == AB_CLR) ? GP_IDLE : GP_WAIT;
      end
    endcase
  end

endmodule

// File: rtl/gate_state_reg.sv
module gate_state_reg
  import gate_pass_pkg::*;
#(
  parameter gp_state_t RESET_STATE = GP_IDLE
) (
  input  logic      clk,
  input  logic      rst,
  input  gp_state_t nxt,
  output gp_state_t st
);

  always_ff @(posedge clk) begin
    if (rst) st <= RESET_STATE;
    else     st <= nxt;
  end

endmodule

// File: rtl/gate_pulse_reg.sv
module gate_pulse_reg #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] fire,
  output logic [LANES-1:0] pulse
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= fire[i];
    end
  end

endmodule

// File: rtl/gate_pass_detector.sv
module gate_pass_detector
  import gate_pass_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sens_outer,
  input  logic sens_inner,
  output logic car_in,
  output logic car_out
);

  localparam int LANES = GP_LANES;

  gp_state_t        st_q;
  gp_state_t        st_d;
  logic [LANES-1:0] fire;
  logic [LANES-1:0] pulse;
  logic [1:0]       ab;

  assign ab = {sens_outer, sens_inner};

  gate_pass_next #(.LANES(LANES)) u_next (
    .st   (st_q),
    .ab   (ab),
    .nxt  (st_d),
    .done (fire)
  );

  gate_state_reg #(.RESET_STATE(GP_IDLE)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (st_d),
    .st  (st_q)
  );

  gate_pulse_reg #(.LANES(LANES)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .pulse (pulse)
  );

  assign car_in  = pulse[GP_LANE_IN];
  assign car_out = pulse[GP_LANE_OUT];

endmodule

// File: rtl/gate_pass_detector_chk.sv
module gate_pass_detector_chk
  import gate_pass_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      sens_outer,
  input logic      sens_inner,
  input logic      car_in,
  input logic      car_out,
  input gp_state_t st
);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !(car_in && car_out));

  p_in_single_r4: assert property (@(posedge clk) disable iff (rst)
    car_in |=> !car_in);

  p_out_single_r4: assert property (@(posedge clk) disable iff (rst)
    car_out |=> !car_out);

  p_in_source_r2: assert property (@(posedge clk) disable iff (rst)
    car_in |-> ($past(st) == GP_IN_B && !$past(sens_outer) && !$past(sens_inner)));

  p_out_source_r3: assert property (@(posedge clk) disable iff (rst)
    car_out |-> ($past(st) == GP_OUT_A && !$past(sens_outer) && !$past(sens_inner)));

  p_back_in_r5: assert property (@(posedge clk) disable iff (rst)
    (st == GP_IN_AB && sens_outer && !sens_inner) |=> st == GP_IN_A);

  p_back_out_r6: assert property (@(posedge clk) disable iff (rst)
    (st == GP_OUT_AB && !sens_outer && sens_inner) |=> st == GP_OUT_B);

  p_short_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (st == GP_IN_A && !sens_outer && !sens_inner) |=> (st == GP_IDLE && !car_in));

  p_short_skip_r7: assert property (@(posedge clk) disable iff (rst)
    (st == GP_IN_A && !sens_outer && sens_inner) |=> st == GP_WAIT);

  p_park_r8: assert property (@(posedge clk) disable iff (rst)
    (st == GP_WAIT && (sens_outer || sens_inner)) |=> (st == GP_WAIT && !car_in && !car_out));

endmodule

bind gate_pass_detector gate_pass_detector_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sens_outer (sens_outer),
  .sens_inner (sens_inner),
  .car_in     (car_in),
  .car_out    (car_out),
  .st         (st_q)
);

// File: tb/gate_pass_detector_test.sv
`timescale 1ns/1ps
module gate_pass_detector_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a   = 1'b0;
  logic b   = 1'b0;
  logic car_in;
  logic car_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic  en;
    logic  ex;
    string tag;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  gate_pass_detector uut (
    .clk        (clk),
    .rst        (rst),
    .sens_outer (a),
    .sens_inner (b),
    .car_in     (car_in),
    .car_out    (car_out)
  );

  // driver: apply one cycle of stimulus and queue the output expected after the next edge
  task automatic step(input logic r, input logic [1:0] ab, input logic en,
                      input logic ex, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r;
    {a, b} = ab;
    e.en = en; e.ex = ex; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic go(input logic [1:0] ab, input string tag);
    step(1'b0, ab, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (car_in !== e.en || car_out !== e.ex) begin
        errors++;
        $display("FAIL %s: in/out=%b%b expected %b%b", e.tag, car_in, car_out, e.en, e.ex);
      end
      checks++;
      if (car_in === 1'b1 && car_out === 1'b1) begin // R9
        errors++;
        $display("FAIL R9: in/out=%b%b expected no overlap", car_in, car_out);
      end
    end
  end

  initial begin
    // R1 reset state
    step(1'b1, 2'b10, 1'b0, 1'b0, "R1");
    step(1'b1, 2'b00, 1'b0, 1'b0, "R1");
    // R2 plain entry, R4 one pulse while clear is held
    go(2'b00, "R2"); go(2'b10, "R2"); go(2'b11, "R2"); go(2'b01, "R2");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R2");
    go(2'b00, "R4"); go(2'b00, "R4");
    // R3 plain exit
    go(2'b01, "R3"); go(2'b11, "R3"); go(2'b10, "R3");
    step(1'b0, 2'b00, 1'b0, 1'b1, "R3");
    go(2'b00, "R4");
    // R4 long dwell in each phase
    for (int i = 0; i < 3; i++) go(2'b10, "R4");
    for (int i = 0; i < 3; i++) go(2'b11, "R4");
    for (int i = 0; i < 3; i++) go(2'b01, "R4");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 3; i++) go(2'b00, "R4");
    // R5 entry backed out, then backed up and resumed
    go(2'b10, "R5"); go(2'b11, "R5"); go(2'b10, "R5"); go(2'b00, "R5"); go(2'b00, "R5");
    go(2'b10, "R5"); go(2'b11, "R5"); go(2'b01, "R5"); go(2'b11, "R5"); go(2'b10, "R5");
    go(2'b00, "R5"); go(2'b00, "R5");
    go(2'b10, "R5"); go(2'b11, "R5"); go(2'b01, "R5"); go(2'b11, "R5"); go(2'b01, "R5");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R5");
    go(2'b00, "R5");
    // R6 exit backed out, then backed up and resumed
    go(2'b01, "R6"); go(2'b11, "R6"); go(2'b01, "R6"); go(2'b00, "R6"); go(2'b00, "R6");
    go(2'b01, "R6"); go(2'b11, "R6"); go(2'b10, "R6"); go(2'b11, "R6"); go(2'b10, "R6");
    step(1'b0, 2'b00, 1'b0, 1'b1, "R6");
    go(2'b00, "R6");
    // R7 short objects
    go(2'b10, "R7"); go(2'b00, "R7"); go(2'b00, "R7");
    go(2'b10, "R7"); go(2'b01, "R7"); go(2'b00, "R7"); go(2'b00, "R7");
    go(2'b01, "R7"); go(2'b00, "R7"); go(2'b00, "R7");
    go(2'b01, "R7"); go(2'b10, "R7"); go(2'b00, "R7"); go(2'b00, "R7");
    // R8 illegal start, parked, then recovery
    go(2'b11, "R8"); go(2'b01, "R8"); go(2'b00, "R8"); go(2'b00, "R8");
    go(2'b10, "R8"); go(2'b11, "R8"); go(2'b01, "R8"); go(2'b10, "R8");
    go(2'b01, "R8"); go(2'b00, "R8"); go(2'b00, "R8");
    go(2'b10, "R8"); go(2'b11, "R8"); go(2'b01, "R8");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R8");
    go(2'b00, "R8");
    // R1 reset mid-passage abandons it
    go(2'b10, "R1"); go(2'b11, "R1"); go(2'b01, "R1");
    step(1'b1, 2'b01, 1'b0, 1'b0, "R1");
    go(2'b00, "R1"); go(2'b00, "R1");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected <= 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule